// File: doc/BRIEF.md
# Acknowledge-Polling Sequencer for an I2C Master

This block sits on the controller side of an I2C bus, above a byte-level master engine. After software or a higher-level controller finishes a write to an EEPROM-style target, the target runs an internal programming cycle. While that cycle runs, the target does not acknowledge its own address. The sequencer turns that silence into a busy indication. On `poll_go` it issues a Start, then the target's control byte with the direction bit cleared. If the byte is not acknowledged, it closes the attempt with a Stop, waits a programmable number of clocks and tries again.

The first acknowledged attempt ends the sequence with a single-cycle `poll_done` pulse. No Stop is sent, so the bus stays claimed and the next read or write can follow straight on from that Start. If the attempt limit is reached first, the sequencer raises `poll_timeout` and returns to idle.

The lower engine takes one command per valid/ready handshake. It answers every command with a single-cycle `rsp_valid`. For a byte transfer, it also reports the acknowledge bit on `rsp_nack`.

Top module: `ackpoll_seq`

## Requirements
- R1: A `poll_go` pulse while idle makes `poll_busy` rise on the next clock and starts an attempt whose first command is a Start (`cmd_op` = 0).
- R2: After the Start response, each attempt sends exactly one byte command (`cmd_op` = 1), and `cmd_byte` equals the 7-bit parameter `TGT_ADDR` in bits 7:1 with bit 0 cleared.
- R3: An acknowledged byte (`rsp_nack` = 0) produces `poll_done` high for exactly one cycle, in the cycle after that response. The block then returns to idle without issuing a Stop.
- R4: A not-acknowledged byte (`rsp_nack` = 1) is always followed by a Stop command (`cmd_op` = 2) before any further Start.
- R5: After the Stop response of a retried attempt, the next Start request (`cmd_valid` with `cmd_op` = 0) first appears exactly `GAP_CYCLES`+1 clocks after the cycle in which that response was presented.
- R6: When `MAX_TRIES` attempts have been refused, the Stop of the last attempt is followed by `poll_timeout` going high and the block going idle. The flag stays high until the next accepted `poll_go`.
- R7: `poll_go` is ignored while `poll_busy` is high; the command stream and the retry count are unchanged.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_byte` hold. Exactly one command is issued per handshake.
- R9: After reset, `poll_busy`, `poll_done`, `poll_timeout` and `cmd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| poll_go | input | 1 | Begin polling (accepted only when idle) |
| poll_busy | output | 1 | Sequence in progress |
| poll_done | output | 1 | One-cycle pulse: target acknowledged, bus left open |
| poll_timeout | output | 1 | Attempt limit reached; held until next accepted start |
| cmd_valid | output | 1 | Command request to the byte-level master |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_op | output | 2 | 0 = Start, 1 = send byte, 2 = Stop |
| cmd_byte | output | 8 | Byte to send for op 1 |
| rsp_valid | input | 1 | One-cycle completion of the accepted command |
| rsp_nack | input | 1 | Byte not acknowledged (valid with a byte response) |

## Verification
A corrupted state register or retry counter shows at the ports as a wrong command count, or as a Start that is not preceded by its Stop. Either shows up within one attempt. A wrong count also shifts the moment of `poll_done` or `poll_timeout` by a whole attempt. A gap counter that loads or decrements wrongly moves the next Start request by a measurable number of clocks. The bench sweeps every busy length from zero to past the limit, with and without back-pressure, so each such fault changes at least one counted figure of the run.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  // Command codes presented to the byte-level master.
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START_REQ,
    ST_START_WAIT,
    ST_ADDR_REQ,
    ST_ADDR_WAIT,
    ST_STOP_REQ,
    ST_STOP_WAIT,
    ST_GAP
  } poll_state_e;

endpackage

// File: rtl/ackpoll_rst_sync.sv
module ackpoll_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/ackpoll_gap_timer.sv
module ackpoll_gap_timer #(
  parameter int GAP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [GAP_W-1:0] RELOAD = GAP_W'(GAP_CYCLES - 1);

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // A load always leaves a count within the programmed window (R5).
  assert_gap_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q <= RELOAD));

endmodule

// File: rtl/ackpoll_try_counter.sv
module ackpoll_try_counter #(
  parameter int MAX_TRIES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_limit
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LIMIT = TRY_W'(MAX_TRIES);

  logic [TRY_W-1:0] tries_q;
  logic [TRY_W-1:0] tries_d;
  logic             tries_en;

  always_comb begin
    tries_en = 1'b0;
    tries_d  = tries_q;
    if (clear) begin
      tries_en = 1'b1;
      tries_d  = '0;
    end else if (bump && (tries_q != LIMIT)) begin
      tries_en = 1'b1;
      tries_d  = tries_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
    end else if (tries_en) begin
      tries_q <= tries_d;
    end
  end

  assign at_limit = (tries_q >= LIMIT);

  // No refused attempt is counted once the limit has been reached (R6).
  assert_tries_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit |-> !bump);

endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR   = 7'h50,
  parameter int         GAP_CYCLES = 8,
  parameter int         MAX_TRIES  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       poll_go,
  output logic       poll_busy,
  output logic       poll_done,
  output logic       poll_timeout,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_byte,
  input  logic       rsp_valid,
  input  logic       rsp_nack
);

  localparam logic [7:0] CTRL_BYTE = {TGT_ADDR, 1'b0};
  localparam bit         HAS_GAP   = (GAP_CYCLES > 0);

  logic        srst_n;
  poll_state_e state_q, state_d;
  logic        done_q, done_d;
  logic        tmo_q, tmo_d;
  logic        try_clear, try_bump, try_at_limit;
  logic        gap_load, gap_run, gap_expired;

  ackpoll_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ackpoll_try_counter #(
    .MAX_TRIES (MAX_TRIES)
  ) u_tries (
    .clk      (clk),
    .rst_n    (srst_n),
    .clear    (try_clear),
    .bump     (try_bump),
    .at_limit (try_at_limit)
  );

  generate
    if (HAS_GAP) begin : g_gap
      ackpoll_gap_timer #(
        .GAP_CYCLES (GAP_CYCLES)
      ) u_gap (
        .clk     (clk),
        .rst_n   (srst_n),
        .load    (gap_load),
        .run     (gap_run),
        .expired (gap_expired)
      );
    end else begin : g_nogap
      logic unused_gap;
      assign unused_gap  = gap_load | gap_run;
      assign gap_expired = 1'b1;
    end
  endgenerate

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    tmo_d     = tmo_q;
    try_clear = 1'b0;
    try_bump  = 1'b0;
    gap_load  = 1'b0;
    gap_run   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (poll_go) begin
          state_d   = ST_START_REQ;
          tmo_d     = 1'b0;
          try_clear = 1'b1;
        end
      end
      ST_START_REQ: begin
        if (cmd_ready) state_d = ST_START_WAIT;
      end
      ST_START_WAIT: begin
        if (rsp_valid) state_d = ST_ADDR_REQ;
      end
      ST_ADDR_REQ: begin
        if (cmd_ready) state_d = ST_ADDR_WAIT;
      end
      ST_ADDR_WAIT: begin
        if (rsp_valid) begin
          if (rsp_nack) begin
            try_bump = 1'b1;
            state_d  = ST_STOP_REQ;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_STOP_REQ: begin
        if (cmd_ready) state_d = ST_STOP_WAIT;
      end
      ST_STOP_WAIT: begin
        if (rsp_valid) begin
          if (try_at_limit) begin
            tmo_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (HAS_GAP) begin
            gap_load = 1'b1;
            state_d  = ST_GAP;
          end else begin
            state_d = ST_START_REQ;
          end
        end
      end
      ST_GAP: begin
        gap_run = 1'b1;
        if (gap_expired) state_d = ST_START_REQ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  // Command outputs decoded from state
  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_START;
    cmd_byte  = 8'h00;
    unique case (state_q)
      ST_START_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_START;
      end
      ST_ADDR_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WRITE;
        cmd_byte  = CTRL_BYTE;
      end
      ST_STOP_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_STOP;
      end
      default: ;
    endcase
  end

  assign poll_busy    = (state_q != ST_IDLE);
  assign poll_done    = done_q;
  assign poll_timeout = tmo_q;

  assert_go_start_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (poll_busy && !$past(poll_busy)) |-> $past(poll_go));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!srst_n)
    poll_done |=> !poll_done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!srst_n)
    poll_done |-> (!poll_busy && !cmd_valid));

  assert_gap_exit_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_GAP && gap_expired) |=> (cmd_valid && cmd_op == OP_START));

  assert_timeout_idle_R6: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(poll_timeout) |-> (!poll_busy && $past(rsp_valid)));

  assert_hold_cmd_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

endmodule

// File: tb/ackpoll_seq_tb.sv
`timescale 1ns/1ps
module ackpoll_seq_tb_top;

  localparam logic [6:0] ADDR = 7'h50;
  localparam int GAP = 3;
  localparam int MAXT = 4;
  localparam logic [7:0] EXP_BYTE = {ADDR, 1'b0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       poll_go = 1'b0;
  logic       poll_busy, poll_done, poll_timeout;
  logic       cmd_valid, cmd_ready;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       rsp_valid, rsp_nack;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  int busy_cfg = 0;
  bit stall_mode = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmd_ready = !stall_mode || cyc[0];

  ackpoll_seq #(.TGT_ADDR(ADDR), .GAP_CYCLES(GAP), .MAX_TRIES(MAXT)) dut_i (
    .clk(clk), .rst_n(rst_n), .poll_go(poll_go), .poll_busy(poll_busy),
    .poll_done(poll_done), .poll_timeout(poll_timeout), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack)
  );

  // Byte-level master model: responds two cycles after each handshake.
  logic       pend;
  logic [1:0] pend_op;
  int         lat;
  int         nacks_given;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_op <= 2'd0; lat <= 0; nacks_given <= 0;
      rsp_valid <= 1'b0; rsp_nack <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_nack  <= 1'b0;
      if (poll_go && !poll_busy) nacks_given <= 0;
      if (pend) begin
        if (lat == 0) begin
          rsp_valid <= 1'b1;
          pend <= 1'b0;
          if (pend_op == 2'd1 && nacks_given < busy_cfg) begin
            rsp_nack <= 1'b1;
            nacks_given <= nacks_given + 1;
          end
        end else begin
          lat <= lat - 1;
        end
      end else if (cmd_valid && cmd_ready) begin
        pend <= 1'b1; pend_op <= cmd_op; lat <= 1;
      end
    end
  end

  // Port monitor, sampled at the falling edge.
  int n_start = 0, n_write = 0, n_stop = 0, n_done = 0;
  int err_byte = 0, err_order = 0, err_gap = 0, err_done = 0, err_hold = 0;
  bit need_stop = 0, gap_arm = 0, done_pend = 0, prev_stall = 0;
  int gap_ref = 0, done_at = 0;
  logic [1:0] prev_op = 2'd0;
  logic [7:0] prev_byte = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!cmd_valid || cmd_op != prev_op || cmd_byte != prev_byte))
        err_hold++;
      prev_stall = cmd_valid && !cmd_ready;
      prev_op = cmd_op;
      prev_byte = cmd_byte;
      if (!poll_busy) gap_arm = 0;
      if (gap_arm && cmd_valid && cmd_op == 2'd0) begin
        if (cyc - gap_ref != GAP + 1) err_gap++;
        gap_arm = 0;
      end
      if (cmd_valid && cmd_ready) begin
        case (cmd_op)
          2'd0: begin n_start++; if (need_stop) err_order++; end
          2'd1: begin n_write++; if (cmd_byte != EXP_BYTE) err_byte++; end
          2'd2: begin n_stop++; need_stop = 0; end
          default: err_order++;
        endcase
      end
      if (rsp_valid && pend_op == 2'd2) begin gap_ref = cyc; gap_arm = 1; end
      if (rsp_valid && pend_op == 2'd1 && rsp_nack) need_stop = 1;
      if (rsp_valid && pend_op == 2'd1 && !rsp_nack) begin done_pend = 1; done_at = cyc + 1; end
      if (poll_done) begin
        n_done++;
        if (!(done_pend && cyc == done_at)) err_done++;
        done_pend = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int b, input bit stall, input bit inject);
    int s0, w0, p0, d0, eb, eo, eg, ed, eh;
    int exp_att, exp_stop;
    bit finished;
    s0 = n_start; w0 = n_write; p0 = n_stop; d0 = n_done;
    eb = err_byte; eo = err_order; eg = err_gap; ed = err_done; eh = err_hold;
    busy_cfg = b;
    stall_mode = stall;
    @(negedge clk); poll_go = 1'b1;
    @(negedge clk); poll_go = 1'b0;
    check(poll_busy == 1'b1, "R1 busy after go", poll_busy, 1);
    check(poll_timeout == 1'b0, "R6 timeout cleared by go", poll_timeout, 0);
    if (inject) begin
      repeat (6) @(negedge clk);
      poll_go = 1'b1;
      @(negedge clk); poll_go = 1'b0;
    end
    finished = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!poll_busy) begin finished = 1; break; end
    end
    check(finished, "watchdog run", 0, 1);
    @(negedge clk);
    exp_att  = (b + 1 < MAXT) ? b + 1 : MAXT;
    exp_stop = (b < MAXT) ? b : MAXT;
    check(n_start - s0 == exp_att, inject ? "R7 starts" : "R1 starts", n_start - s0, exp_att);
    check(n_write - w0 == exp_att, "R2 bytes per attempt", n_write - w0, exp_att);
    check(err_byte == eb, "R2 control byte", err_byte - eb, 0);
    check(n_stop - p0 == exp_stop, "R4 stops", n_stop - p0, exp_stop);
    check(err_order == eo, "R4 stop before start", err_order - eo, 0);
    check(n_done - d0 == ((b < MAXT) ? 1 : 0), "R3 done pulses", n_done - d0, (b < MAXT) ? 1 : 0);
    check(err_done == ed, "R3 done timing", err_done - ed, 0);
    check(err_gap == eg, "R5 retry gap", err_gap - eg, 0);
    check(poll_timeout == (b >= MAXT), "R6 timeout flag", poll_timeout, (b >= MAXT) ? 1 : 0);
    check(err_hold == eh, "R8 command hold", err_hold - eh, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(poll_busy == 1'b0, "R9 busy reset", poll_busy, 0);
    check(poll_done == 1'b0, "R9 done reset", poll_done, 0);
    check(poll_timeout == 1'b0, "R9 timeout reset", poll_timeout, 0);
    check(cmd_valid == 1'b0, "R9 cmd_valid reset", cmd_valid, 0);
    for (int s = 0; s < 2; s++)
      for (int b = 0; b <= MAXT + 1; b++)
        run_case(b, s[0], 1'b0);
    run_case(1, 1'b0, 1'b1);
    run_case(2, 1'b1, 1'b1);
    run_case(0, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule